// File: doc/BRIEF.md
# Host/DSP Word Mailbox

This block couples a host processor and a DSP core through two independent one-word channels. In the outbound path the DSP pushes a word into a local transmit slot; on its own, the block moves that word into a host-visible receive slot as soon as the host slot is empty. In the inbound path the host writes a transmit slot, and the block moves the word into a DSP-side receive slot. Each slot has a full flag, and each automatic move updates the flags on both sides.

All four data ports use valid/ready. A word transfers on a rising clock edge where both valid and ready are high. The DSP transmit port raises ready only while its slot is empty. The host transmit port raises ready only while its slot is empty and no flush is applied in that cycle. The host receive port drops valid in a cycle where a flush is applied. A move between the slots of one channel happens on the edge that follows the cycle in which the source is full and the destination is empty. A full destination therefore stalls the source for as long as it stays full. The control inputs (configuration write, request enables, initialise, host reset) and the status outputs are plain levels sampled on the clock.

The host status word uses these bits: bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is the receive request enable and bit 3 is the transmit request enable. The host request line combines the enabled flags.

Top module: `hdx_mailbox`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `host_csr` reads 4'b0010, `host_req` is 0, `dsp_tx_ready` is 1, `dsp_rx_valid` is 0 and `host_rx_valid` is 0.
- R2: A DSP word accepted at edge t is taken out of the DSP transmit slot at edge t+1, provided the host receive slot is empty and no receive flush occurs. After edge t+1, `host_csr[0]` is 1, `host_rx_data` holds the word and `dsp_tx_ready` is 1 again.
- R3: A host read (`host_rx_valid` and `host_rx_ready` high at an edge) clears `host_csr[0]` at that edge. No new word enters the host receive slot on the same edge.
- R4: A host write accepted at an edge clears `host_csr[1]` at that edge. If the DSP receive slot is empty, the next edge moves the word there, sets `dsp_rx_valid` with the word on `dsp_rx_data`, and sets `host_csr[1]` again.
- R5: While the destination slot of a channel is full, the source slot keeps its word and its full state. The move happens on the edge after the destination is drained. Words arrive in the order they were written.
- R6: A configuration write with `cfg_init`=1 and `cfg_rx_req_en`=1 clears `host_csr[0]` and discards the held word. `host_rx_valid` is 0 during that cycle, and no outbound move happens on that edge.
- R7: A configuration write with `cfg_init`=1 and `cfg_tx_req_en`=1 sets `host_csr[1]` and discards the host transmit word. `host_tx_ready` is 0 during that cycle, and no inbound move happens on that edge.
- R8: A configuration write loads the two request enables, which appear on `host_csr[2]` (receive) and `host_csr[3]` (transmit). An initialise whose enable is 0 leaves the matching flag unchanged.
- R9: A `host_rst` pulse clears `host_csr[0]`, sets `host_csr[1]` and discards both host-side words. The request enables keep their values.
- R10: `host_req` is 1 exactly when (`host_csr[2]` and `host_csr[0]`) or (`host_csr[3]` and `host_csr[1]`).
- R11: `host_csr[0]` and `host_csr[1]` track the slot state whatever the request enables are, so the host can poll them with requests off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_tx_valid | input | 1 | DSP offers an outbound word |
| dsp_tx_ready | output | 1 | DSP transmit slot is empty |
| dsp_tx_data | input | DATA_W | Outbound word from the DSP |
| host_rx_valid | output | 1 | Host receive slot holds a word |
| host_rx_ready | input | 1 | Host takes the word |
| host_rx_data | output | DATA_W | Word presented to the host |
| host_tx_valid | input | 1 | Host offers an inbound word |
| host_tx_ready | output | 1 | Host transmit slot can take a word |
| host_tx_data | input | DATA_W | Inbound word from the host |
| dsp_rx_valid | output | 1 | DSP receive slot holds a word |
| dsp_rx_ready | input | 1 | DSP takes the word |
| dsp_rx_data | output | DATA_W | Word presented to the DSP |
| host_rst | input | 1 | Host-side reset pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rx_req_en | input | 1 | Receive request enable value |
| cfg_tx_req_en | input | 1 | Transmit request enable value |
| cfg_init | input | 1 | Initialise with this write |
| host_csr | output | 4 | Host status: full, empty, enables |
| host_req | output | 1 | Host request line |

## Verification
The bench builds the block with its default 32-bit word. Distinct patterns in the upper and lower halves of each word expose any mixing of the two channels' data paths. Directed phases stall each channel with a full destination, run an initialise and a host reset against pending words, and switch the request enables with the flags in every state. A long random phase then applies simultaneous reads, writes, initialises and resets on a single edge, which exercises the same-edge priority among flush, load and move.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int unsigned CSR_W   = 4;
  localparam int unsigned RXF_BIT = 0;
  localparam int unsigned TXE_BIT = 1;
  localparam int unsigned RQE_BIT = 2;
  localparam int unsigned TQE_BIT = 3;
endpackage

// File: rtl/hdx_slot.sv
module hdx_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         unload,
  input  logic         flush,
  output logic         full,
  output logic [W-1:0] data
);
  // flush beats load, load beats unload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (flush) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      data <= ld_data;
    end else if (unload) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/hdx_channel.sv
module hdx_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  input  logic         src_flush,
  input  logic         dst_flush,
  output logic         src_full,
  output logic         dst_full
);
  logic         xfer;
  logic [W-1:0] src_data;

  assign in_ready  = ~src_full & ~src_flush;
  assign out_valid = dst_full & ~dst_flush;
  assign xfer      = src_full & ~dst_full & ~src_flush & ~dst_flush;

  hdx_slot #(.W(W)) i_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid & in_ready),
    .ld_data (in_data),
    .unload  (xfer),
    .flush   (src_flush),
    .full    (src_full),
    .data    (src_data)
  );

  hdx_slot #(.W(W)) i_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (xfer),
    .ld_data (src_data),
    .unload  (out_valid & out_ready),
    .flush   (dst_flush),
    .full    (dst_full),
    .data    (out_data)
  );
endmodule

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
  import hdx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rx_req_en,
  input  logic             cfg_tx_req_en,
  input  logic             cfg_init,
  input  logic             host_rst,
  input  logic             rx_full,
  input  logic             tx_full,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic [CSR_W-1:0] csr,
  output logic             host_req
);
  logic rqe, tqe, init_now;

  assign init_now = cfg_wr & cfg_init;
  assign rx_flush = host_rst | (init_now & cfg_rx_req_en);
  assign tx_flush = host_rst | (init_now & cfg_tx_req_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rqe <= 1'b0;
      tqe <= 1'b0;
    end else if (cfg_wr) begin
      rqe <= cfg_rx_req_en;
      tqe <= cfg_tx_req_en;
    end
  end

  always_comb begin
    csr          = '0;
    csr[RXF_BIT] = rx_full;
    csr[TXE_BIT] = ~tx_full;
    csr[RQE_BIT] = rqe;
    csr[TQE_BIT] = tqe;
  end

  assign host_req = (rqe & rx_full) | (tqe & ~tx_full);
endmodule

// File: rtl/hdx_mailbox.sv
module hdx_mailbox
  import hdx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsp_tx_valid,
  output logic              dsp_tx_ready,
  input  logic [DATA_W-1:0] dsp_tx_data,
  output logic              host_rx_valid,
  input  logic              host_rx_ready,
  output logic [DATA_W-1:0] host_rx_data,
  input  logic              host_tx_valid,
  output logic              host_tx_ready,
  input  logic [DATA_W-1:0] host_tx_data,
  output logic              dsp_rx_valid,
  input  logic              dsp_rx_ready,
  output logic [DATA_W-1:0] dsp_rx_data,
  input  logic              host_rst,
  input  logic              cfg_wr,
  input  logic              cfg_rx_req_en,
  input  logic              cfg_tx_req_en,
  input  logic              cfg_init,
  output logic [CSR_W-1:0]  host_csr,
  output logic              host_req
);
  logic d2h_src_full, rx_full;
  logic tx_full, h2d_dst_full;
  logic rx_flush, tx_flush;

  hdx_channel #(.W(DATA_W)) i_d2h (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dsp_tx_valid),
    .in_ready  (dsp_tx_ready),
    .in_data   (dsp_tx_data),
    .out_valid (host_rx_valid),
    .out_ready (host_rx_ready),
    .out_data  (host_rx_data),
    .src_flush (1'b0),
    .dst_flush (rx_flush),
    .src_full  (d2h_src_full),
    .dst_full  (rx_full)
  );

  hdx_channel #(.W(DATA_W)) i_h2d (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (host_tx_valid),
    .in_ready  (host_tx_ready),
    .in_data   (host_tx_data),
    .out_valid (dsp_rx_valid),
    .out_ready (dsp_rx_ready),
    .out_data  (dsp_rx_data),
    .src_flush (tx_flush),
    .dst_flush (1'b0),
    .src_full  (tx_full),
    .dst_full  (h2d_dst_full)
  );

  hdx_ctrl i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_rx_req_en (cfg_rx_req_en),
    .cfg_tx_req_en (cfg_tx_req_en),
    .cfg_init      (cfg_init),
    .host_rst      (host_rst),
    .rx_full       (rx_full),
    .tx_full       (tx_full),
    .rx_flush      (rx_flush),
    .tx_flush      (tx_flush),
    .csr           (host_csr),
    .host_req      (host_req)
  );
endmodule

// File: rtl/hdx_mailbox_chk.sv
module hdx_mailbox_chk
  import hdx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dsp_tx_ready,
  input logic              host_rx_valid,
  input logic              host_rx_ready,
  input logic [DATA_W-1:0] host_rx_data,
  input logic              host_tx_valid,
  input logic              host_tx_ready,
  input logic              dsp_rx_valid,
  input logic              dsp_rx_ready,
  input logic              host_rst,
  input logic              cfg_wr,
  input logic              cfg_rx_req_en,
  input logic              cfg_tx_req_en,
  input logic              cfg_init,
  input logic [CSR_W-1:0]  host_csr,
  input logic              host_req,
  input logic              rx_flush,
  input logic              tx_flush,
  input logic              d2h_src_full,
  input logic              h2d_dst_full
);
  p_d2h_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (d2h_src_full && !host_csr[RXF_BIT] && !rx_flush) |=> (!d2h_src_full && host_csr[RXF_BIT]));

  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rx_valid && host_rx_ready) |=> !host_csr[RXF_BIT]);

  p_write_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_valid && host_tx_ready) |=> !host_csr[TXE_BIT]);

  p_h2d_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_csr[TXE_BIT] && !h2d_dst_full && !tx_flush) |=> (h2d_dst_full && host_csr[TXE_BIT]));

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_csr[RXF_BIT] && !(host_rx_valid && host_rx_ready) && !rx_flush)
      |=> ($stable(host_rx_data) && host_csr[RXF_BIT]));

  p_drx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_rx_valid && !dsp_rx_ready) |=> dsp_rx_valid);

  p_init_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_init && cfg_rx_req_en) |=> !host_csr[RXF_BIT]);

  p_init_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_init && cfg_tx_req_en) |=> host_csr[TXE_BIT]);

  p_hrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rst |=> (host_csr[RXF_BIT:TXE_BIT-1] == 1'b0 && host_csr[TXE_BIT]));

  p_req_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_csr[RQE_BIT] && !host_csr[TQE_BIT]) |-> !host_req);

  p_dsp_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsp_tx_ready && !host_csr[RXF_BIT] && !rx_flush) |=> dsp_tx_ready);
endmodule

bind hdx_mailbox hdx_mailbox_chk #(.DATA_W(DATA_W)) i_hdx_mailbox_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dsp_tx_ready  (dsp_tx_ready),
  .host_rx_valid (host_rx_valid),
  .host_rx_ready (host_rx_ready),
  .host_rx_data  (host_rx_data),
  .host_tx_valid (host_tx_valid),
  .host_tx_ready (host_tx_ready),
  .dsp_rx_valid  (dsp_rx_valid),
  .dsp_rx_ready  (dsp_rx_ready),
  .host_rst      (host_rst),
  .cfg_wr        (cfg_wr),
  .cfg_rx_req_en (cfg_rx_req_en),
  .cfg_tx_req_en (cfg_tx_req_en),
  .cfg_init      (cfg_init),
  .host_csr      (host_csr),
  .host_req      (host_req),
  .rx_flush      (rx_flush),
  .tx_flush      (tx_flush),
  .d2h_src_full  (d2h_src_full),
  .h2d_dst_full  (h2d_dst_full)
);

// File: tb/test_hdx_mailbox.sv
module test_hdx_mailbox;
  localparam int CLK_P = 10;
  localparam int W     = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dsp_tx_valid = 0, host_rx_ready = 0, host_tx_valid = 0, dsp_rx_ready = 0;
  logic [W-1:0] dsp_tx_data = '0, host_tx_data = '0;
  logic         host_rst = 0, cfg_wr = 0, cfg_rx_req_en = 0, cfg_tx_req_en = 0, cfg_init = 0;
  logic         dsp_tx_ready, host_rx_valid, host_tx_ready, dsp_rx_valid, host_req;
  logic [W-1:0] host_rx_data, dsp_rx_data;
  logic [3:0]   host_csr;

  int    errors = 0, checks = 0;
  bit    done = 0, run = 0;
  string cur_req = "R1";

  // reference model state: each slot is a queue of at most one word
  logic [W-1:0] q_dtx[$], q_hrx[$], q_htx[$], q_drx[$];
  bit m_rqe = 0, m_tqe = 0;

  always #(CLK_P/2) clk = ~clk;

  hdx_mailbox #(.DATA_W(W)) i_hdx_mailbox (
    .clk(clk), .rst_n(rst_n),
    .dsp_tx_valid(dsp_tx_valid), .dsp_tx_ready(dsp_tx_ready), .dsp_tx_data(dsp_tx_data),
    .host_rx_valid(host_rx_valid), .host_rx_ready(host_rx_ready), .host_rx_data(host_rx_data),
    .host_tx_valid(host_tx_valid), .host_tx_ready(host_tx_ready), .host_tx_data(host_tx_data),
    .dsp_rx_valid(dsp_rx_valid), .dsp_rx_ready(dsp_rx_ready), .dsp_rx_data(dsp_rx_data),
    .host_rst(host_rst), .cfg_wr(cfg_wr), .cfg_rx_req_en(cfg_rx_req_en),
    .cfg_tx_req_en(cfg_tx_req_en), .cfg_init(cfg_init),
    .host_csr(host_csr), .host_req(host_req)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit rx_drop();
    return host_rst | (cfg_wr & cfg_init & cfg_rx_req_en);
  endfunction
  function automatic bit tx_drop();
    return host_rst | (cfg_wr & cfg_init & cfg_tx_req_en);
  endfunction

  // model update on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q_dtx.delete(); q_hrx.delete(); q_htx.delete(); q_drx.delete();
      m_rqe = 0; m_tqe = 0;
    end else begin
      automatic bit rd  = (q_hrx.size() != 0) && !rx_drop() && host_rx_ready;
      automatic bit wr  = (q_htx.size() == 0) && !tx_drop() && host_tx_valid;
      automatic bit dw  = (q_dtx.size() == 0) && dsp_tx_valid;
      automatic bit dr  = (q_drx.size() != 0) && dsp_rx_ready;
      automatic bit mvo = (q_dtx.size() != 0) && (q_hrx.size() == 0) && !rx_drop();
      automatic bit mvi = (q_htx.size() != 0) && (q_drx.size() == 0) && !tx_drop();
      if (rx_drop()) q_hrx.delete();
      if (tx_drop()) q_htx.delete();
      if (rd) void'(q_hrx.pop_front());
      if (dr) void'(q_drx.pop_front());
      if (mvo) q_hrx.push_back(q_dtx.pop_front());
      if (mvi) q_drx.push_back(q_htx.pop_front());
      if (dw) q_dtx.push_back(dsp_tx_data);
      if (wr) q_htx.push_back(host_tx_data);
      if (cfg_wr) begin m_rqe = cfg_rx_req_en; m_tqe = cfg_tx_req_en; end
    end
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && run) begin
      automatic bit hf = q_hrx.size() != 0;
      automatic bit te = q_htx.size() == 0;
      chk(cur_req, "host_csr", host_csr, {m_tqe, m_rqe, te, hf});
      chk("R10", "host_req", host_req, (m_rqe & hf) | (m_tqe & te));
      chk(cur_req, "dsp_tx_ready", dsp_tx_ready, q_dtx.size() == 0);
      chk(cur_req, "dsp_rx_valid", dsp_rx_valid, q_drx.size() != 0);
      chk(cur_req, "host_rx_valid", host_rx_valid, hf & !rx_drop());
      chk(cur_req, "host_tx_ready", host_tx_ready, te & !tx_drop());
      if (hf) chk(cur_req, "host_rx_data", host_rx_data, q_hrx[0]);
      if (q_drx.size() != 0) chk(cur_req, "dsp_rx_data", dsp_rx_data, q_drx[0]);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic dsp_push(input logic [W-1:0] d);
    dsp_tx_valid = 1; dsp_tx_data = d; step(); dsp_tx_valid = 0;
  endtask
  task automatic host_push(input logic [W-1:0] d);
    host_tx_valid = 1; host_tx_data = d; step(); host_tx_valid = 0;
  endtask
  task automatic cfg(input bit rq, input bit tq, input bit ini);
    cfg_wr = 1; cfg_rx_req_en = rq; cfg_tx_req_en = tq; cfg_init = ini;
    step(); cfg_wr = 0; cfg_init = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    step(3);
    rst_n = 1; #1;
    // R1 reset state
    chk("R1", "csr", host_csr, 4'b0010);
    chk("R1", "req", host_req, 0);
    chk("R1", "dsp_tx_ready", dsp_tx_ready, 1);
    chk("R1", "dsp_rx_valid", dsp_rx_valid, 0);
    chk("R1", "host_rx_valid", host_rx_valid, 0);
    run = 1;

    cur_req = "R2";
    dsp_push(32'hA5A5_0001);
    chk("R2", "ready after accept", dsp_tx_ready, 0);
    chk("R2", "rxf before move", host_csr[0], 0);
    step();
    chk("R2", "rxf after move", host_csr[0], 1);
    chk("R2", "word", host_rx_data, 32'hA5A5_0001);
    chk("R2", "ready again", dsp_tx_ready, 1);
    chk("R11", "rxf polled with requests off", {host_req, host_csr[0]}, 2'b01);

    cur_req = "R5";
    dsp_push(32'h0002_5A5A);
    step(3);
    chk("R5", "source held", dsp_tx_ready, 0);
    chk("R5", "dest kept", host_rx_data, 32'hA5A5_0001);

    cur_req = "R3";
    host_rx_ready = 1; step(); host_rx_ready = 0;
    chk("R3", "rxf cleared by read", host_csr[0], 0);
    step();
    chk("R5", "second word after drain", host_rx_data, 32'h0002_5A5A);
    host_rx_ready = 1; step(); host_rx_ready = 0;

    cur_req = "R4";
    host_push(32'h1111_EEEE);
    chk("R4", "txe cleared by write", host_csr[1], 0);
    step();
    chk("R4", "txe after move", host_csr[1], 1);
    chk("R4", "dsp word", dsp_rx_data, 32'h1111_EEEE);
    host_push(32'h2222_DDDD);
    step(2);
    chk("R5", "host tx held", host_csr[1], 0);
    dsp_rx_ready = 1; step(); dsp_rx_ready = 0;
    step();
    chk("R5", "inbound order", dsp_rx_data, 32'h2222_DDDD);
    dsp_rx_ready = 1; step(); dsp_rx_ready = 0;

    cur_req = "R8";
    dsp_push(32'h3333_CCCC); step();
    cfg(0, 0, 1);
    chk("R8", "init without enable keeps rxf", host_csr[0], 1);
    cfg(1, 1, 0);
    chk("R8", "enables shown", host_csr[3:2], 2'b11);
    chk("R10", "req from rxf", host_req, 1);

    cur_req = "R6";
    cfg(1, 1, 1);
    chk("R6", "rxf cleared by init", host_csr[1:0], 2'b10);
    chk("R10", "req from txe", host_req, 1);
    cfg(1, 0, 0);
    chk("R10", "req off", host_req, 0);

    cur_req = "R7";
    host_push(32'h4444_BBBB); step();
    host_push(32'h5555_AAAA);
    chk("R7", "txe cleared", host_csr[1], 0);
    cfg(1, 1, 1);
    chk("R7", "txe set by init", host_csr[1], 1);
    dsp_rx_ready = 1; step(); dsp_rx_ready = 0;
    step(2);
    chk("R7", "discarded word not delivered", dsp_rx_valid, 0);

    cur_req = "R9";
    dsp_push(32'h6666_9999); step();
    host_push(32'h7777_8888); step();
    host_push(32'h8888_7777);
    host_rst = 1; step(); host_rst = 0;
    chk("R9", "csr after host reset", host_csr, 4'b1110);
    dsp_rx_ready = 1; step(); dsp_rx_ready = 0;
    step(2);
    chk("R9", "no word after host reset", dsp_rx_valid, 0);

    cur_req = "R5";
    for (int i = 0; i < 4000; i++) begin
      dsp_tx_valid  = $urandom_range(0, 1);
      dsp_tx_data   = $urandom;
      host_tx_valid = $urandom_range(0, 1);
      host_tx_data  = $urandom;
      host_rx_ready = $urandom_range(0, 2) != 0;
      dsp_rx_ready  = $urandom_range(0, 2) != 0;
      cfg_wr        = $urandom_range(0, 15) == 0;
      cfg_init      = $urandom_range(0, 1);
      cfg_rx_req_en = $urandom_range(0, 1);
      cfg_tx_req_en = $urandom_range(0, 1);
      host_rst      = $urandom_range(0, 63) == 0;
      step();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule